// File: doc/BRIEF.md
# Converter Chip-Select Serial Port with End-of-Conversion Flag

This block is the digital face of a successive-approximation converter that is run in a four-wire, chip-select style serial mode with an end-of-conversion flag. A host raises the convert strobe `cnv` while `sdi` is high. That starts a conversion of a fixed length, counted in system clock cycles. For the whole conversion the serial output is released (high impedance).

When the conversion ends with `sdi` low, the port starts driving `sdo` low. A host with a pull-up on the line sees this falling level as its interrupt. The block then enters the acquisition phase. The host clocks the captured sample out on `sck`, most significant bit first. Each bit appears on a falling edge of `sck` and holds through the next rising edge, so the host may sample on either edge. The line is released again on the first of two events: the falling edge after the last bit, or a rising edge of `sdi`. Dropping `cnv` at any point returns the port to idle. In idle, the port drives `sdo` low whenever `cnv` and `sdi` are both low.

All pins are sampled on the system clock `clk`. The sample word comes from a stand-in data source on `sample_data` and is captured at the end of the conversion.

Top module: `sar_cs_port`

## Requirements
- R1: In idle, a rising edge of `cnv` seen while `sdi` is high starts a conversion, and `sdo_oe` is 0 from the following cycle.
- R2: A rising edge of `cnv` seen while `sdi` is low starts nothing. The port stays idle, and `sdo_oe` stays 0 while `cnv` is high, however long that lasts.
- R3: A conversion lasts exactly CONV_CYCLES clock cycles after the start edge, with `sdo_oe` 0 throughout. Toggling `sck` or `sdi` during those cycles does not change this.
- R4: If `sdi` is low in the last conversion cycle, then from the next cycle `sdo_oe` is 1 and `sdo` is 0. This is the end-of-conversion flag.
- R5: If `sdi` is high in the last conversion cycle, no flag is produced. `sdo_oe` stays 0, and `sck` edges have no effect, until `cnv` goes low.
- R6: During readout, falling edge k of `sck` (k = 1..DATA_W) puts bit DATA_W-k of the sample on `sdo`, so the most significant bit comes first. The value holds until the next falling edge.
- R7: Falling edge DATA_W+1 of `sck` sets `sdo_oe` to 0, and later `sck` edges leave it at 0.
- R8: A rising edge of `sdi` during readout sets `sdo_oe` to 0 in the next cycle, whatever number of bits has been read.
- R9: In idle with `cnv` low, `sdo_oe` equals NOT `sdi`, and `sdo` is 0 whenever it is driven.
- R10: `cnv` low during conversion, readout or the released state after readout returns the port to idle in the next cycle.
- R11: The sample word is the value of `sample_data` in the last conversion cycle. Later changes to `sample_data` do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Convert strobe; rising edge starts a conversion, must stay high through readout |
| sdi | input | 1 | Mode select at the start edge; rising edge during readout ends it |
| sck | input | 1 | Serial clock from the host; falling edges advance the data |
| sample_data | input | DATA_W | Parallel sample from the stand-in data source |
| sdo | output | 1 | Serial data / end-of-conversion level |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 models high impedance |

## Verification
The bench builds the block with DATA_W = 14 and CONV_CYCLES = 5. The short conversion lets it check the enable at every conversion cycle and the exact cycle of the flag. It also keeps each full pass of start, flag, 14 bits and release short enough to repeat for walking-one, all-zero, all-one and alternating words. With this configuration the bench can end the readout early with `sdi` after every possible number of bits from 0 to 13. It also covers the released-without-flag path, starts ignored because `sdi` was low, and the strobe dropping in the middle of a conversion or a readout.

// File: rtl/sar_cs_pkg.sv
package sar_cs_pkg;

    // Port phases: idle, conversion running, acquisition with data readout,
    // acquisition with the line released.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_READOUT = 2'd2,
        ST_DONE    = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pulse
);

    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = sig & ~sig_q;
        end else begin : g_fall
            assign pulse = ~sig & sig_q;
        end
    endgenerate

endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
    parameter int CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = (CONV_CYCLES < 2) ? 1 : $clog2(CONV_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (start)                  cnt_q <= CNT_W'(CONV_CYCLES - 1);
        else if (run && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign expire = run && (cnt_q == '0);

endmodule

// File: rtl/sar_out_shifter.sv
module sar_out_shifter #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              shift,
    output logic              bit_out,
    output logic              last
);

    localparam int CNT_W = $clog2(DATA_W + 2);

    // One leading zero ahead of the word: the end-of-conversion level.
    logic [DATA_W:0]  sh_q;
    logic [CNT_W-1:0] nfall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            nfall_q <= '0;
        end else if (load) begin
            sh_q    <= {1'b0, data};
            nfall_q <= '0;
        end else if (shift) begin
            sh_q    <= {sh_q[DATA_W-1:0], 1'b0};
            if (nfall_q != CNT_W'(DATA_W)) nfall_q <= nfall_q + 1'b1;
        end
    end

    assign bit_out = sh_q[DATA_W];
    assign last    = (nfall_q == CNT_W'(DATA_W));

endmodule

// File: rtl/sar_cs_port.sv
module sar_cs_port
    import sar_cs_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int CONV_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv,
    input  logic              sdi,
    input  logic              sck,
    input  logic [DATA_W-1:0] sample_data,
    output logic              sdo,
    output logic              sdo_oe
);

    sar_state_e st_q, st_d;

    logic cnv_rise, sdi_rise, sck_fall;
    logic conv_start, conv_expire;
    logic rd_load, rd_shift, rd_bit, rd_last;

    sar_edge_det #(.RISING(1'b1)) u_cnv_edge (
        .clk(clk), .rst_n(rst_n), .sig(cnv), .pulse(cnv_rise));
    sar_edge_det #(.RISING(1'b1)) u_sdi_edge (
        .clk(clk), .rst_n(rst_n), .sig(sdi), .pulse(sdi_rise));
    sar_edge_det #(.RISING(1'b0)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .sig(sck), .pulse(sck_fall));

    sar_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (conv_start),
        .run    (st_q == ST_CONVERT),
        .expire (conv_expire)
    );

    sar_out_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rd_load),
        .data    (sample_data),
        .shift   (rd_shift),
        .bit_out (rd_bit),
        .last    (rd_last)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions and datapath strobes.
    always_comb begin
        st_d       = st_q;
        conv_start = 1'b0;
        rd_load    = 1'b0;
        rd_shift   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cnv_rise && sdi) begin
                    st_d       = ST_CONVERT;
                    conv_start = 1'b1;
                end
            end
            ST_CONVERT: begin
                if (!cnv) begin
                    st_d = ST_IDLE;
                end else if (conv_expire) begin
                    if (sdi) begin
                        st_d = ST_DONE;
                    end else begin
                        st_d    = ST_READOUT;
                        rd_load = 1'b1;
                    end
                end
            end
            ST_READOUT: begin
                if (!cnv) begin
                    st_d = ST_IDLE;
                end else if (sdi_rise) begin
                    st_d = ST_DONE;
                end else if (sck_fall) begin
                    if (rd_last) st_d = ST_DONE;
                    else         rd_shift = 1'b1;
                end
            end
            ST_DONE: begin
                if (!cnv) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Pin outputs.
    always_comb begin
        sdo    = 1'b0;
        sdo_oe = 1'b0;
        unique case (st_q)
            ST_IDLE:    sdo_oe = !cnv && !sdi;
            ST_READOUT: begin
                sdo_oe = 1'b1;
                sdo    = rd_bit;
            end
            ST_CONVERT,
            ST_DONE:    sdo_oe = 1'b0;
            default:    sdo_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_cs_port_chk.sv
module sar_cs_port_chk
    import sar_cs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cnv,
    input logic       sdi,
    input logic       sdo,
    input logic       sdo_oe,
    input sar_state_e st,
    input logic       cnv_rise,
    input logic       sdi_rise,
    input logic       sck_fall,
    input logic       rd_last
);

    AST_START_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cnv_rise && sdi) |=> (st == ST_CONVERT && !sdo_oe)); // R1

    AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cnv_rise && !sdi) |=> (st == ST_IDLE)); // R2

    AST_EOC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sdo_oe) && st == ST_READOUT) |-> !sdo); // R4

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READOUT && cnv && !sck_fall && !sdi_rise) |=> $stable(sdo)); // R6

    AST_LAST_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READOUT && cnv && sck_fall && rd_last) |=> !sdo_oe); // R7

    AST_SDI_END: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READOUT && cnv && sdi_rise) |=> !sdo_oe); // R8

    AST_CNV_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !cnv) |=> (st == ST_IDLE)); // R10

endmodule

bind sar_cs_port sar_cs_port_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnv      (cnv),
    .sdi      (sdi),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .st       (st_q),
    .cnv_rise (cnv_rise),
    .sdi_rise (sdi_rise),
    .sck_fall (sck_fall),
    .rd_last  (rd_last)
);

// File: tb/sar_cs_port_tb.sv
module sar_cs_port_tb_top;

    localparam int DW    = 14;
    localparam int CONV  = 5;
    localparam int NPAT  = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnv = 1'b0;
    logic          sdi = 1'b0;
    logic          sck = 1'b0;
    logic [DW-1:0] sdata = '0;
    logic          sdo, sdo_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sar_cs_port #(.DATA_W(DW), .CONV_CYCLES(CONV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdi(sdi), .sck(sck),
        .sample_data(sdata), .sdo(sdo), .sdo_oe(sdo_oe));

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_hiz(string req);
        n_chk++;
        if (sdo_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: sdo_oe=%b expected 0 (released)", req, sdo_oe);
        end
    endtask

    task automatic check_drive(string req, logic exp);
        n_chk++;
        if (sdo_oe !== 1'b1 || sdo !== exp) begin
            n_fail++;
            $display("FAIL %s: sdo_oe=%b sdo=%b expected sdo_oe=1 sdo=%b",
                     req, sdo_oe, sdo, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(int i);
        if (i < DW)       return DW'(1) << i;
        else if (i == DW) return '0;
        else if (i == DW + 1) return '1;
        else if (i == DW + 2) return DW'(14'h2AAA);
        else              return DW'(14'h1555);
    endfunction

    // Start a conversion with word w; sdi takes value end_sdi in the last
    // conversion cycle. Returns at the first cycle after the conversion.
    task automatic start_conv(logic [DW-1:0] w, logic end_sdi);
        sdata = w;
        cnv   = 1'b1;
        sdi   = 1'b1;
        tick();
        check_hiz("R1 start");
        for (int k = 1; k <= CONV; k++) begin
            if (k > 1) check_hiz("R3 conversion");
            sck = k[0];
            sdi = (k == CONV) ? end_sdi : k[0];
            tick();
        end
        sck   = 1'b0;
        sdata = ~w;
    endtask

    // Clock out n bits of word w, checking hold and value of each.
    task automatic read_bits(logic [DW-1:0] w, int n);
        logic prev = 1'b0;
        for (int b = 1; b <= n; b++) begin
            sck = 1'b1;
            tick();
            check_drive("R6 hold over rising edge", prev);
            sck = 1'b0;
            tick();
            check_drive("R6/R11 bit value", w[DW-b]);
            prev = w[DW-b];
        end
    endtask

    task automatic to_idle(string req);
        cnv = 1'b0;
        sdi = 1'b0;
        tick();
        check_drive(req, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        sdi = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check_hiz("R9 reset idle sdi high");
        sdi = 1'b0;
        tick();
        check_drive("R9 idle cnv low sdi low", 1'b0);

        // Full readouts over a sweep of words.
        for (int i = 0; i < NPAT; i++) begin
            start_conv(pat(i), 1'b0);
            check_drive("R4 end of conversion flag", 1'b0);
            read_bits(pat(i), DW);
            sck = 1'b1; tick();
            sck = 1'b0; tick();
            check_hiz("R7 final falling edge");
            sck = 1'b1; tick();
            sck = 1'b0; tick();
            check_hiz("R7 extra sck ignored");
            to_idle("R10 done to idle");
        end

        // Early end by sdi rising after j bits.
        for (int j = 0; j < DW; j++) begin
            logic [DW-1:0] w = DW'(14'h2A5C) ^ DW'(j * 613);
            start_conv(w, 1'b0);
            check_drive("R4 flag", 1'b0);
            read_bits(w, j);
            sdi = 1'b1;
            tick();
            check_hiz("R8 sdi rise ends readout");
            to_idle("R10 after early end");
        end

        // No flag when sdi is high at the end of conversion.
        start_conv(pat(DW + 1), 1'b1);
        check_hiz("R5 no flag");
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; tick();
            sck = 1'b0; tick();
            check_hiz("R5 sck ignored");
        end
        sdi = 1'b0;
        tick();
        check_hiz("R5 still released");
        cnv = 1'b0;
        sdi = 1'b1;
        tick();
        check_hiz("R9 idle sdi high");
        sdi = 1'b0;
        tick();
        check_drive("R9 idle both low", 1'b0);

        // Start edge with sdi low does nothing.
        cnv = 1'b1;
        sdi = 1'b0;
        tick();
        for (int k = 0; k < CONV + 3; k++) begin
            check_hiz("R2 no conversion");
            tick();
        end
        sdi = 1'b1;
        tick();
        check_hiz("R2 sdi change without cnv edge");
        to_idle("R2 back to idle");

        // Strobe dropped in the middle of a conversion.
        sdata = '1;
        cnv   = 1'b1;
        sdi   = 1'b1;
        tick();
        sdi = 1'b0;
        tick();
        check_hiz("R3 conversion in progress");
        to_idle("R10 abort conversion");
        for (int k = 0; k < CONV + 2; k++) begin
            tick();
            check_drive("R10 stays idle", 1'b0);
        end

        // Strobe dropped in the middle of a readout.
        start_conv(pat(DW + 1), 1'b0);
        check_drive("R4 flag", 1'b0);
        read_bits(pat(DW + 1), 1);
        to_idle("R10 abort readout");

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule